// File: doc/BRIEF.md
# Dual-Rail Startup and Fault Supervisor

This block is the digital controller behind two synchronous buck rails, a 3.3 V rail (rail 0) and a 5 V rail (rail 1). Each clock is one switching cycle. The block reads a shutdown input, two rail control inputs and a two-bit sequence select. It also reads per-rail flags from analog comparators, outside this block, for a deep undervoltage (output 30 % low), a shallow droop (output 5 % low) and an overvoltage, plus a die over-temperature flag. From these it produces the rail enables and a soft-start current-limit code for each rail. It also drives a power-good output, a low-side force for overvoltage events, a latched-fault status and an operating mode.

The first control input (`run3`) always gates the rails. The second (`time5`) is either a plain enable for the 5 V rail or, in the ordered modes, the flag that says the external timing capacitor has crossed its threshold. Faults latch both rails off. They stay latched until the controller is shut down or `run3` changes level.

Top module: `rail_supervisor`

## Requirements
- R1: When the controller is shut down (`shdn_n` low), `rail_en` is 0 one cycle later, `mode` reads 0, every current-limit code returns to 0 and `fault_latched` clears. When `shdn_n` is high, `mode` reads 1 (standby) while neither rail is enabled and 2 (run) while at least one is enabled.
- R2: With `seq_sel` 0 (independent; code 3 behaves the same), `rail_en[0]` follows `run3` and `rail_en[1]` follows `time5`, each one cycle after the input, unless a fault is latched.
- R3: With `seq_sel` 1 (5 V first), `rail_en[1]` follows `run3`, and `rail_en[0]` is high only while both `run3` and `time5` are high.
- R4: With `seq_sel` 2 (3.3 V first), `rail_en[0]` follows `run3`, and `rail_en[1]` is high only while both `run3` and `time5` are high.
- R5: A rail's current-limit code (0 to 5, in steps of 20 % of full limit) is 0 in the cycle its enable rises. It goes up by one every SS_CYCLES/5 enabled cycles and stays at 5. It returns to 0 while the rail is off.
- R6: `sys_rst_n` stays low until the monitored rails have been enabled and free of droop for PG_DELAY consecutive cycles, and then goes high. Independent mode monitors rail 0 only. The ordered modes monitor both rails, so a droop on rail 1 has no effect in independent mode.
- R7: A droop flag on a monitored rail pulls `sys_rst_n` low in the same cycle, and the full PG_DELAY count restarts once the droop clears.
- R8: A rail's deep-undervoltage flag is ignored during its first UV_BLANK enabled cycles. After that window it latches a fault, and both enables drop in the same edge.
- R9: An overvoltage flag on either rail latches a fault. Both enables drop on the next edge and both `lowside_on` bits go high, and they stay high while the fault is latched.
- R10: A latched fault clears only on an edge where `run3` differs from its value on the previous edge, or on shutdown. Holding `run3` steady keeps the fault latched. A fault source that is present in the same cycle wins over the clear.
- R11: The over-temperature flag `ot_flag` acts exactly like shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_n | input | 1 | Controller enable; low means shutdown |
| ot_flag | input | 1 | Die over-temperature flag |
| run3 | input | 1 | First control input; gates the rails |
| time5 | input | 1 | 5 V enable (independent mode) or timer-crossed flag (ordered modes) |
| seq_sel | input | 2 | 0 independent, 1 5 V first, 2 3.3 V first, 3 independent |
| uv30 | input | 2 | Per-rail deep undervoltage flag |
| uv5 | input | 2 | Per-rail droop flag |
| ov | input | 2 | Per-rail overvoltage flag |
| rail_en | output | 2 | Rail enables, bit 0 = 3.3 V, bit 1 = 5 V |
| ilim3 | output | 3 | Soft-start limit code for the 3.3 V rail |
| ilim5 | output | 3 | Soft-start limit code for the 5 V rail |
| lowside_on | output | 2 | Force low-side switch on, per rail |
| sys_rst_n | output | 1 | Power-good, low while rails are not good |
| mode | output | 2 | 0 shutdown, 1 standby, 2 run |
| fault_latched | output | 1 | A rail fault is latched |

## Verification
If the soft-start sub-counter is miscounted, the limit code steps one or more cycles early or late, and the first step already shows this at SS_CYCLES/5 cycles after enable. A wrong blanking counter makes a deep undervoltage held from enable trip the fault one edge early or late at the end of the window. A wrong power-good count moves the rising edge of `sys_rst_n` away from exactly PG_DELAY cycles, and a wrong monitored-rail selection shows at once as a droop on the wrong rail pulling it low. A fault latch that clears on level rather than on change shows up within a few cycles of holding `run3` high after a trip.

// File: rtl/rail_sup_pkg.sv
`timescale 1ns/1ps
package rail_sup_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STBY = 2'd1,
    MODE_RUN  = 2'd2
  } sup_mode_e;

  localparam logic [1:0] SEQ_INDEP       = 2'd0;
  localparam logic [1:0] SEQ_FIVE_FIRST  = 2'd1;
  localparam logic [1:0] SEQ_THREE_FIRST = 2'd2;

  localparam int          N_RAILS   = 2;
  localparam int          ILIM_W    = 3;
  localparam int          ILIM_LVLS = 5;
  localparam logic [2:0]  ILIM_FULL = 3'd5;
endpackage

// File: rtl/ss_ramp.sv
`timescale 1ns/1ps
module ss_ramp
  import rail_sup_pkg::*;
#(
  parameter int STEP = 102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [ILIM_W-1:0] code
);
  localparam int SW = $clog2(STEP + 1);

  logic [SW-1:0] sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      code  <= '0;
    end else if (!en) begin
      sub_q <= '0;
      code  <= '0;
    end else if (code != ILIM_FULL) begin
      if (sub_q == SW'(STEP - 1)) begin
        sub_q <= '0;
        code  <= ILIM_W'(code + 1'b1);
      end else begin
        sub_q <= SW'(sub_q + 1'b1);
      end
    end
  end

  p_code_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code <= ILIM_FULL);
  p_code_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (code == $past(code)) || (code == ILIM_W'($past(code) + 1'b1)));
  p_code_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> code == '0);
endmodule

// File: rtl/uv_blank.sv
`timescale 1ns/1ps
module uv_blank #(
  parameter int BLANK = 6144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic armed
);
  localparam int CW = $clog2(BLANK + 1);

  logic [CW-1:0] cnt_q;

  assign armed = (cnt_q == CW'(BLANK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (!armed) cnt_q <= CW'(cnt_q + 1'b1);
  end

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed);
  p_arm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en) |=> armed);
endmodule

// File: rtl/pg_timer.sv
`timescale 1ns/1ps
module pg_timer #(
  parameter int DELAY = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic good
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == CW'(DELAY));
  assign good = cond && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!cond) cnt_q <= '0;
    else if (!done) cnt_q <= CW'(cnt_q + 1'b1);
  end

  p_pg_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good) |-> $past(cond));
  p_pg_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !good);
endmodule

// File: rtl/rail_supervisor.sv
`timescale 1ns/1ps
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int SS_CYCLES = 512,
  parameter int UV_BLANK  = 6144,
  parameter int PG_DELAY  = 32000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              ot_flag,
  input  logic              run3,
  input  logic              time5,
  input  logic [1:0]        seq_sel,
  input  logic [1:0]        uv30,
  input  logic [1:0]        uv5,
  input  logic [1:0]        ov,
  output logic [1:0]        rail_en,
  output logic [ILIM_W-1:0] ilim3,
  output logic [ILIM_W-1:0] ilim5,
  output logic [1:0]        lowside_on,
  output logic              sys_rst_n,
  output logic [1:0]        mode,
  output logic              fault_latched
);
  localparam int SS_STEP = (SS_CYCLES / ILIM_LVLS > 1) ? SS_CYCLES / ILIM_LVLS : 2;

  logic                 sd;
  logic                 run3_q;
  logic                 toggle;
  logic [N_RAILS-1:0]   req;
  logic [N_RAILS-1:0]   en_q, en_nx;
  logic [N_RAILS-1:0]   armed;
  logic                 fault_q, fault_nx, fault_set;
  logic                 ovl_q, ovl_nx;
  logic                 ordered;
  logic                 mon_ok;
  logic [ILIM_W-1:0]    code [N_RAILS];
  sup_mode_e            mode_v;

  assign sd     = !shdn_n || ot_flag;
  assign toggle = (run3 != run3_q);

  // Rail requests per sequence mode
  always_comb begin
    ordered = 1'b0;
    case (seq_sel)
      SEQ_FIVE_FIRST: begin
        ordered = 1'b1;
        req     = {run3, run3 && time5};
      end
      SEQ_THREE_FIRST: begin
        ordered = 1'b1;
        req     = {run3 && time5, run3};
      end
      default: req = {time5, run3};
    endcase
  end

  // Fault latch: a source wins over a clear in the same cycle
  assign fault_set = (|ov) || (|(uv30 & armed));

  always_comb begin
    if (sd)             fault_nx = 1'b0;
    else if (fault_set) fault_nx = 1'b1;
    else if (toggle)    fault_nx = 1'b0;
    else                fault_nx = fault_q;

    if (sd)          ovl_nx = 1'b0;
    else if (|ov)    ovl_nx = 1'b1;
    else if (toggle) ovl_nx = 1'b0;
    else             ovl_nx = ovl_q;

    en_nx = sd ? '0 : (req & {N_RAILS{!fault_nx}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run3_q  <= 1'b0;
      fault_q <= 1'b0;
      ovl_q   <= 1'b0;
      en_q    <= '0;
    end else begin
      run3_q  <= run3;
      fault_q <= fault_nx;
      ovl_q   <= ovl_nx;
      en_q    <= en_nx;
    end
  end

  // Per-rail soft-start and undervoltage blanking
  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    ss_ramp #(.STEP(SS_STEP)) i_ss (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_q[g]),
      .code (code[g])
    );
    uv_blank #(.BLANK(UV_BLANK)) i_uvb (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_q[g]),
      .armed(armed[g])
    );
  end

  // Power-good monitoring set
  assign mon_ok = ordered ? (&en_q) && !(|uv5) : en_q[0] && !uv5[0];

  pg_timer #(.DELAY(PG_DELAY)) i_pg (
    .clk  (clk),
    .rst_n(rst_n),
    .cond (mon_ok),
    .good (sys_rst_n)
  );

  always_comb begin
    if (sd)         mode_v = MODE_OFF;
    else if (|en_q) mode_v = MODE_RUN;
    else            mode_v = MODE_STBY;
  end

  assign mode          = mode_v;
  assign rail_en       = en_q;
  assign ilim3         = code[0];
  assign ilim5         = code[1];
  assign lowside_on    = {N_RAILS{ovl_q}};
  assign fault_latched = fault_q;

  p_sd_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sd |=> (rail_en == '0) && !fault_latched);
  p_ov_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd && (|ov)) |=> fault_latched && (lowside_on == 2'b11) && (rail_en == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !sd && (run3 == run3_q)) |=> fault_latched);
  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd && (|(uv30 & armed))) |=> (rail_en == '0));
endmodule

// File: tb/test_rail_supervisor.sv
`timescale 1ns/1ps
module test_rail_supervisor;
  localparam int SS   = 20;
  localparam int STEP = SS / 5;
  localparam int UVB  = 30;
  localparam int PGD  = 50;

  logic       clk = 1'b0;
  logic       rst_n, shdn_n, ot_flag, run3, time5;
  logic [1:0] seq_sel, uv30, uv5, ov;
  logic [1:0] rail_en, lowside_on, mode;
  logic [2:0] ilim3, ilim5;
  logic       sys_rst_n, fault_latched;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rail_supervisor #(.SS_CYCLES(SS), .UV_BLANK(UVB), .PG_DELAY(PGD)) i_rail_supervisor (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ot_flag(ot_flag), .run3(run3),
    .time5(time5), .seq_sel(seq_sel), .uv30(uv30), .uv5(uv5), .ov(ov),
    .rail_en(rail_en), .ilim3(ilim3), .ilim5(ilim5), .lowside_on(lowside_on),
    .sys_rst_n(sys_rst_n), .mode(mode), .fault_latched(fault_latched)
  );

  // {seq_sel, run3, time5, expected rail_en, expected mode}
  localparam int NV = 13;
  localparam logic [7:0] TBL [NV] = '{
    {2'd0, 1'b0, 1'b0, 2'b00, 2'd1},
    {2'd0, 1'b1, 1'b0, 2'b01, 2'd2},
    {2'd0, 1'b0, 1'b1, 2'b10, 2'd2},
    {2'd0, 1'b1, 1'b1, 2'b11, 2'd2},
    {2'd1, 1'b0, 1'b0, 2'b00, 2'd1},
    {2'd1, 1'b1, 1'b0, 2'b10, 2'd2},
    {2'd1, 1'b1, 1'b1, 2'b11, 2'd2},
    {2'd1, 1'b0, 1'b1, 2'b00, 2'd1},
    {2'd2, 1'b1, 1'b0, 2'b01, 2'd2},
    {2'd2, 1'b1, 1'b1, 2'b11, 2'd2},
    {2'd2, 1'b0, 1'b1, 2'b00, 2'd1},
    {2'd3, 1'b1, 1'b0, 2'b01, 2'd2},
    {2'd3, 1'b0, 1'b1, 2'b10, 2'd2}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; shdn_n = 1'b0; ot_flag = 1'b0; run3 = 1'b0; time5 = 1'b0;
    seq_sel = 2'd0; uv30 = '0; uv5 = '0; ov = '0;
    tick(3);
    check("R1", "reset mode", mode, 0);
    check("R1", "reset rail_en", rail_en, 0);
    check("R1", "reset ilim3", ilim3, 0);
    check("R6", "reset sys_rst_n", sys_rst_n, 0);
    check("R10", "reset fault", fault_latched, 0);
    rst_n = 1'b1;
    tick(1);
    shdn_n = 1'b1;
    tick(1);
    check("R1", "standby mode", mode, 1);

    // Sequencing table (R2, R3, R4)
    for (int k = 0; k < NV; k++) begin
      string tag;
      seq_sel = TBL[k][7:6]; run3 = TBL[k][5]; time5 = TBL[k][4];
      tag = (TBL[k][7:6] == 2'd1) ? "R3" : (TBL[k][7:6] == 2'd2) ? "R4" : "R2";
      tick(1);
      check(tag, $sformatf("vec %0d rail_en", k), rail_en, TBL[k][3:2]);
      check("R1", $sformatf("vec %0d mode", k), mode, TBL[k][1:0]);
    end
    seq_sel = 2'd0; run3 = 1'b0; time5 = 1'b0;
    tick(2);

    // Soft-start staircase (R5)
    run3 = 1'b1;
    tick(1);
    check("R5", "ilim3 at enable", ilim3, 0);
    tick(STEP - 1);
    check("R5", "ilim3 before first step", ilim3, 0);
    tick(1);
    check("R5", "ilim3 first step", ilim3, 1);
    tick(4 * STEP);
    check("R5", "ilim3 full", ilim3, 5);
    tick(STEP);
    check("R5", "ilim3 saturates", ilim3, 5);
    check("R5", "ilim5 while off", ilim5, 0);
    run3 = 1'b0;
    tick(2);
    check("R5", "ilim3 after disable", ilim3, 0);

    // Power-good delay, independent mode (R6, R7)
    run3 = 1'b1;
    tick(1);
    tick(PGD - 1);
    check("R6", "pg before delay", sys_rst_n, 0);
    tick(1);
    check("R6", "pg after delay", sys_rst_n, 1);
    uv5[1] = 1'b1;
    #1;
    check("R6", "5 V droop ignored in independent", sys_rst_n, 1);
    uv5[0] = 1'b1;
    #1;
    check("R7", "droop pulls pg low", sys_rst_n, 0);
    tick(1);
    uv5 = '0;
    tick(1);
    check("R7", "pg restarts after droop", sys_rst_n, 0);
    tick(PGD - 1);
    check("R7", "pg back after full delay", sys_rst_n, 1);

    // Power-good in ordered mode (R6, R3)
    run3 = 1'b0;
    tick(2);
    seq_sel = 2'd1; time5 = 1'b0; run3 = 1'b1;
    tick(1);
    check("R3", "5 V only before timer", rail_en, 2);
    tick(PGD + 2);
    check("R6", "pg waits for both rails", sys_rst_n, 0);
    time5 = 1'b1;
    tick(1);
    check("R3", "both rails after timer", rail_en, 3);
    tick(PGD - 1);
    check("R6", "ordered pg before delay", sys_rst_n, 0);
    tick(1);
    check("R6", "ordered pg after delay", sys_rst_n, 1);

    // Undervoltage blanking and latch (R8, R10)
    run3 = 1'b0; time5 = 1'b0; seq_sel = 2'd0;
    tick(2);
    uv30[0] = 1'b1; run3 = 1'b1;
    tick(1);
    tick(UVB);
    check("R8", "uv ignored in window", fault_latched, 0);
    check("R8", "rail on in window", rail_en, 1);
    tick(1);
    check("R8", "uv latches after window", fault_latched, 1);
    check("R8", "rails off on uv", rail_en, 0);
    check("R9", "no low-side force on uv", lowside_on, 0);
    uv30 = '0;
    tick(5);
    check("R10", "fault holds with run3 steady", fault_latched, 1);
    check("R10", "rails stay off", rail_en, 0);
    run3 = 1'b0;
    tick(1);
    check("R10", "run3 change clears fault", fault_latched, 0);
    run3 = 1'b1;
    tick(1);
    check("R10", "rail back after clear", rail_en, 1);

    // Overvoltage (R9) and clear by shutdown (R10, R1)
    time5 = 1'b1;
    tick(1);
    ov[1] = 1'b1;
    tick(1);
    check("R9", "ov latches", fault_latched, 1);
    check("R9", "ov rails off", rail_en, 0);
    check("R9", "ov low-side on", lowside_on, 3);
    ov = '0;
    tick(3);
    check("R9", "low-side held", lowside_on, 3);
    shdn_n = 1'b0;
    tick(1);
    check("R10", "shutdown clears fault", fault_latched, 0);
    check("R1", "shutdown mode", mode, 0);
    check("R9", "low-side released", lowside_on, 0);
    shdn_n = 1'b1;
    tick(1);
    check("R1", "run after shutdown", rail_en, 3);
    check("R1", "run mode", mode, 2);

    // Over-temperature (R11)
    ot_flag = 1'b1;
    tick(1);
    check("R11", "ot rails off", rail_en, 0);
    check("R11", "ot mode", mode, 0);
    tick(1);
    check("R11", "ot ilim reset", ilim3, 0);
    ot_flag = 1'b0;
    tick(1);
    check("R11", "rails after ot", rail_en, 3);

    summary();
  end
endmodule